// File: doc/BRIEF.md
# Dual-Channel Converter Command Register File

This block sits behind a two-wire serial slave front end and turns the bytes written to a dual 10-bit converter into register updates. Each channel keeps a pending (input) code, an active (output) code that drives the converter, and a 2-bit power-down mode. A four-bit command in the upper half of the first data byte selects whether new data goes to the pending registers, to the active registers, or both, and whether pending values are moved to the active side. One channel or both can be addressed.

The front end handles addressing, START/STOP detection and acknowledge generation. It gives this block a one-cycle pulse for each START or repeated START and for each STOP. It also gives a one-cycle `byte_valid_i` pulse with the received byte at the falling clock edge of that byte's acknowledge. Nothing is written until the last byte of a command has been acknowledged, so a transfer cut short by START or STOP leaves every register as it was. A two-stage extended command reaches the power-down modes. Another extended command chooses which channel the two readback bytes, always present at the outputs, describe.

Top module: `dac_cmd_regfile`

## Requirements
- R1: After reset all pending and active codes are 0, both power-down modes are 2'b11, and readback shows channel A: `rd_hi_o` = 8'h30, `rd_lo_o` = 8'h00.
- R2: The first byte is {cmd[3:0], code[9:6]}. The second byte is {code[5:0], 2'b00}, and its two low bits are ignored. Command 4'h0 writes the code to both the pending and the active register of channel A and moves pending B to active B. Command 4'h1 does the same with the channels swapped.
- R3: Commands 4'h4 and 4'h5 write only pending A or pending B. Neither active code changes.
- R4: Commands 4'h8 and 4'h9 first move both pending codes to the active side, then write the new code to pending A or pending B.
- R5: Command 4'hC writes the code to all four code registers. Command 4'hD writes it to both pending registers only.
- R6: Command 4'hE moves both pending codes to the active side when its single byte is acknowledged; its low nibble is ignored. The byte that follows in the same transfer is a new command byte.
- R7: Command byte 8'hF0 makes the next byte a power-down byte {4'bx, selB, selA, mode[1:0]} (selB at bit 3, selA at bit 2). Every selected channel takes the mode; an unselected channel keeps its mode.
- R8: The mode codes are 2'b00 active, 2'b01 floating, 2'b10 1k to ground and 2'b11 100k to ground. Changing a mode never changes a pending or active code, so a channel set back to 2'b00 resumes its earlier code.
- R9: Command byte 8'hF1 selects channel A for readback and 8'hF2 selects channel B. The readback bytes are `rd_hi_o` = {2'b00, mode, active[9:6]} and `rd_lo_o` = {active[5:0], 2'b00} of the selected channel.
- R10: A START or STOP pulse before the last byte of a command has been acknowledged discards the partial command, and no register changes. The next byte is then a command byte.
- R11: Command nibbles 2, 3, 6, 7, 10 and 11, command 4'hF with a low nibble other than 0, 1 or 2, and any byte after a readback select are acknowledged but change nothing until the next START or STOP.
- R12: Registers change only on a cycle with `byte_valid_i` high and neither START nor STOP pulsing, and they take their new values one clock after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse on START or repeated START addressed to this device |
| stop_i | input | 1 | One-cycle pulse on STOP |
| byte_valid_i | input | 1 | One-cycle pulse at the acknowledge falling edge of a written byte |
| byte_i | input | 8 | Received byte, valid with byte_valid_i |
| code_a_o | output | 10 | Active code of channel A |
| code_b_o | output | 10 | Active code of channel B |
| pd_a_o | output | 2 | Power-down mode of channel A |
| pd_b_o | output | 2 | Power-down mode of channel B |
| rd_hi_o | output | 8 | First readback byte of the selected channel |
| rd_lo_o | output | 8 | Second readback byte of the selected channel |

## Verification
On every cycle, the assertions check four things. Nothing changes without an accepted byte or while a START or STOP is pulsing. A power-down byte never disturbs the codes. A pending-only write never moves an active code. A transfer-only command never waits for a data byte. Only the scenarios show the values that land in each register: which pending value reaches the other channel, whether a transfer happens before or after the new pending write, how the channel select bits are masked, and how the readback bytes are packed. A behavioural model in the bench, written as command-by-command cases, covers these values on every clock.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    localparam int CODE_W = 10;
    localparam int NCH    = 2;
    localparam int PD_W   = 2;
    localparam int CMD_W  = 4;
    localparam int HI_W   = CODE_W - 6;
    localparam logic [PD_W-1:0] PD_RESET = 2'b11;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_PDB  = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef struct packed {
        logic [NCH-1:0] ld_in;
        logic [NCH-1:0] ld_out;
        logic [NCH-1:0] xfer;
        logic           two_byte;
        logic           ext_pd;
        logic           rd_arm;
        logic           rd_b;
        logic           skip;
    } cmd_dec_t;

    typedef struct packed {
        phase_e                         phase;
        logic [CMD_W-1:0]               cmd;
        logic [HI_W-1:0]                hi;
        logic [NCH-1:0][CODE_W-1:0]     in_r;
        logic [NCH-1:0][CODE_W-1:0]     out_r;
        logic [NCH-1:0][PD_W-1:0]       pd;
        logic                           rd_b;
    } rf_state_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [HI_W-1:0]  hi_i,
    output cmd_dec_t         dec_o
);
    logic [NCH-1:0] sel_mask;

    always_comb begin
        sel_mask = cmd_i[0] ? 2'b10 : 2'b01;
        dec_o    = '0;
        unique case (cmd_i)
            4'h0, 4'h1: begin
                dec_o.ld_in    = sel_mask;
                dec_o.ld_out   = sel_mask;
                dec_o.xfer     = ~sel_mask;
                dec_o.two_byte = 1'b1;
            end
            4'h4, 4'h5: begin
                dec_o.ld_in    = sel_mask;
                dec_o.two_byte = 1'b1;
            end
            4'h8, 4'h9: begin
                dec_o.ld_in    = sel_mask;
                dec_o.xfer     = '1;
                dec_o.two_byte = 1'b1;
            end
            4'hC: begin
                dec_o.ld_in    = '1;
                dec_o.ld_out   = '1;
                dec_o.two_byte = 1'b1;
            end
            4'hD: begin
                dec_o.ld_in    = '1;
                dec_o.two_byte = 1'b1;
            end
            4'hE: dec_o.xfer = '1;
            4'hF: begin
                if (hi_i == 4'h0)      dec_o.ext_pd = 1'b1;
                else if (hi_i == 4'h1) dec_o.rd_arm = 1'b1;
                else if (hi_i == 4'h2) begin
                    dec_o.rd_arm = 1'b1;
                    dec_o.rd_b   = 1'b1;
                end else                dec_o.skip   = 1'b1;
            end
            default: dec_o.skip = 1'b1;
        endcase
    end
endmodule

// File: rtl/dac_readback_fmt.sv
module dac_readback_fmt
    import dac_cmd_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [PD_W-1:0]   pd_i,
    output logic [7:0]        hi_o,
    output logic [7:0]        lo_o
);
    always_comb begin
        hi_o = {2'b00, pd_i, code_i[CODE_W-1:6]};
        lo_o = {code_i[5:0], 2'b00};
    end
endmodule

// File: rtl/dac_cmd_regfile.sv
module dac_cmd_regfile
    import dac_cmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic [PD_W-1:0]   pd_a_o,
    output logic [PD_W-1:0]   pd_b_o,
    output logic [7:0]        rd_hi_o,
    output logic [7:0]        rd_lo_o
);
    rf_state_t         s_d, s_q;
    cmd_dec_t          dec;
    logic [CMD_W-1:0]  cmd_sel;
    logic [HI_W-1:0]   hi_sel;
    logic [CODE_W-1:0] new_code;
    logic              frame_edge;

    assign frame_edge = start_i | stop_i;
    assign cmd_sel    = (s_q.phase == PH_CMD) ? byte_i[7:4] : s_q.cmd;
    assign hi_sel     = (s_q.phase == PH_CMD) ? byte_i[3:0] : s_q.hi;
    assign new_code   = {s_q.hi, byte_i[7:2]};

    dac_cmd_decode dec_i (
        .cmd_i (cmd_sel),
        .hi_i  (hi_sel),
        .dec_o (dec)
    );

    always_comb begin
        s_d = s_q;
        if (frame_edge) begin
            s_d.phase = PH_CMD;
        end else if (byte_valid_i) begin
            unique case (s_q.phase)
                PH_CMD: begin
                    s_d.cmd = byte_i[7:4];
                    s_d.hi  = byte_i[3:0];
                    if (dec.skip) begin
                        s_d.phase = PH_SKIP;
                    end else if (dec.rd_arm) begin
                        s_d.rd_b  = dec.rd_b;
                        s_d.phase = PH_SKIP;
                    end else if (dec.ext_pd) begin
                        s_d.phase = PH_PDB;
                    end else if (dec.two_byte) begin
                        s_d.phase = PH_DATA;
                    end else begin
                        for (int i = 0; i < NCH; i++)
                            if (dec.xfer[i]) s_d.out_r[i] = s_q.in_r[i];
                    end
                end
                PH_DATA: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (dec.ld_out[i])    s_d.out_r[i] = new_code;
                        else if (dec.xfer[i]) s_d.out_r[i] = s_q.in_r[i];
                        if (dec.ld_in[i])     s_d.in_r[i]  = new_code;
                    end
                    s_d.phase = PH_CMD;
                end
                PH_PDB: begin
                    for (int i = 0; i < NCH; i++)
                        if (byte_i[PD_W+i]) s_d.pd[i] = byte_i[PD_W-1:0];
                    s_d.phase = PH_CMD;
                end
                default: s_d.phase = PH_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.phase <= PH_CMD;
            s_q.cmd   <= '0;
            s_q.hi    <= '0;
            s_q.in_r  <= '0;
            s_q.out_r <= '0;
            s_q.pd    <= {NCH{PD_RESET}};
            s_q.rd_b  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_a_o = s_q.out_r[0];
    assign code_b_o = s_q.out_r[1];
    assign pd_a_o   = s_q.pd[0];
    assign pd_b_o   = s_q.pd[1];

    dac_readback_fmt fmt_i (
        .code_i (s_q.out_r[s_q.rd_b]),
        .pd_i   (s_q.pd[s_q.rd_b]),
        .hi_o   (rd_hi_o),
        .lo_o   (rd_lo_o)
    );

    // R12
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !byte_valid_i |=> ($stable(code_a_o) && $stable(code_b_o) &&
                           $stable(pd_a_o) && $stable(pd_b_o) && $stable(rd_hi_o)));

    // R10
    abort_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_edge |=> ($stable(code_a_o) && $stable(code_b_o) &&
                        $stable(pd_a_o) && $stable(pd_b_o)));

    // R8
    pd_keeps_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_PDB && byte_valid_i && !frame_edge)
            |=> ($stable(code_a_o) && $stable(code_b_o)));

    // R3
    pend_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_DATA && byte_valid_i && !frame_edge && s_q.cmd[3:1] == 3'b010)
            |=> ($stable(code_a_o) && $stable(code_b_o)));

    // R6
    xfer_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_DATA) |-> (s_q.cmd != 4'hE));
endmodule

// File: tb/dac_cmd_regfile_tb.sv
module dac_cmd_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stop = 1'b0, bv = 1'b0;
    logic [7:0] bval = 8'h00;
    logic [9:0] code_a, code_b;
    logic [1:0] pd_a, pd_b;
    logic [7:0] rd_hi, rd_lo;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    dac_cmd_regfile dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
        .byte_valid_i(bv), .byte_i(bval),
        .code_a_o(code_a), .code_b_o(code_b), .pd_a_o(pd_a), .pd_b_o(pd_b),
        .rd_hi_o(rd_hi), .rd_lo_o(rd_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference model, one command case at a time
    int m_in[2], m_out[2], m_pd[2], m_sel, m_ph, m_cmd, m_hi;
    always @(posedge clk) begin
        int b, d;
        b = bval;
        if (!rst_n) begin
            m_in = '{0, 0}; m_out = '{0, 0}; m_pd = '{3, 3};
            m_sel = 0; m_ph = 0; m_cmd = 0; m_hi = 0;
        end else if (start || stop) begin
            m_ph = 0;
        end else if (bv) begin
            case (m_ph)
                0: begin
                    m_cmd = b / 16; m_hi = b % 16;
                    if (m_cmd == 14) begin m_out[0] = m_in[0]; m_out[1] = m_in[1]; end
                    else if (m_cmd == 15) begin
                        if (m_hi == 0) m_ph = 2;
                        else if (m_hi == 1) begin m_sel = 0; m_ph = 3; end
                        else if (m_hi == 2) begin m_sel = 1; m_ph = 3; end
                        else m_ph = 3;
                    end else if (m_cmd inside {0, 1, 4, 5, 8, 9, 12, 13}) m_ph = 1;
                    else m_ph = 3;
                end
                1: begin
                    d = m_hi * 64 + b / 4;
                    case (m_cmd)
                        0:  begin m_out[1] = m_in[1]; m_in[0] = d; m_out[0] = d; end
                        1:  begin m_out[0] = m_in[0]; m_in[1] = d; m_out[1] = d; end
                        4:  m_in[0] = d;
                        5:  m_in[1] = d;
                        8:  begin m_out[0] = m_in[0]; m_out[1] = m_in[1]; m_in[0] = d; end
                        9:  begin m_out[0] = m_in[0]; m_out[1] = m_in[1]; m_in[1] = d; end
                        12: begin m_in = '{d, d}; m_out = '{d, d}; end
                        13: m_in = '{d, d};
                        default: ;
                    endcase
                    m_ph = 0;
                end
                2: begin
                    if ((b / 4) % 2 == 1) m_pd[0] = b % 4;
                    if ((b / 8) % 2 == 1) m_pd[1] = b % 4;
                    m_ph = 0;
                end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " code A"}, int'(code_a), m_out[0]);
            chk({cur_req, " code B"}, int'(code_b), m_out[1]);
            chk({cur_req, " mode A"}, int'(pd_a), m_pd[0]);
            chk({cur_req, " mode B"}, int'(pd_b), m_pd[1]);
            chk({cur_req, " rd hi"}, int'(rd_hi), m_pd[m_sel] * 16 + m_out[m_sel] / 64);
            chk({cur_req, " rd lo"}, int'(rd_lo), (m_out[m_sel] % 64) * 4);
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); bv = 1'b1; bval = b; @(negedge clk); bv = 1'b0;
    endtask
    task automatic wr2(input logic [3:0] c, input logic [9:0] v);
        pulse_start();
        send({c, v[9:6]});
        send({v[5:0], 2'b01});
        pulse_stop();
    endtask
    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        cur_req = "R1";
        chk("R1 code A", code_a, 0);     chk("R1 code B", code_b, 0);
        chk("R1 mode A", pd_a, 3);       chk("R1 mode B", pd_b, 3);
        chk("R1 rd hi", rd_hi, 8'h30);   chk("R1 rd lo", rd_lo, 8'h00);

        cur_req = "R7";
        pulse_start(); send(8'hF0); send(8'h0C); pulse_stop(); settle();
        chk("R7 wake both A", pd_a, 0); chk("R7 wake both B", pd_b, 0);

        cur_req = "R2";
        wr2(4'h0, 10'h155); settle();
        chk("R2 load A", code_a, 10'h155); chk("R2 B from pending", code_b, 0);

        cur_req = "R3";
        wr2(4'h5, 10'h2AA); settle();
        chk("R3 A held", code_a, 10'h155); chk("R3 B held", code_b, 0);

        cur_req = "R2";
        wr2(4'h0, 10'h0F0); settle();
        chk("R2 load A again", code_a, 10'h0F0); chk("R2 B takes pending", code_b, 10'h2AA);

        cur_req = "R4";
        wr2(4'h4, 10'h3FF);
        wr2(4'h9, 10'h011); settle();
        chk("R4 A transferred", code_a, 10'h3FF); chk("R4 B old pending", code_b, 10'h2AA);

        cur_req = "R6";
        pulse_start(); send(8'hE5); settle();
        chk("R6 B transfer", code_b, 10'h011); chk("R6 A transfer", code_a, 10'h3FF);
        send(8'hC8); send(8'h00); pulse_stop(); settle();
        chk("R6 follow-on cmd A", code_a, 10'h200); chk("R6 follow-on cmd B", code_b, 10'h200);

        cur_req = "R10";
        pulse_start(); send(8'hC4); pulse_stop(); settle();
        chk("R10 stop abort", code_a, 10'h200);
        pulse_start(); send(8'hC4); pulse_start(); send(8'h00); pulse_stop(); settle();
        chk("R10 restart abort A", code_a, 10'h200); chk("R10 restart abort B", code_b, 10'h200);

        cur_req = "R5";
        wr2(4'hD, 10'h123); settle();
        chk("R5 pending only", code_a, 10'h200);
        pulse_start(); send(8'hE0); pulse_stop(); settle();
        chk("R5 both pending A", code_a, 10'h123); chk("R5 both pending B", code_b, 10'h123);

        cur_req = "R8";
        pulse_start(); send(8'hF0); send(8'hF6); pulse_stop(); settle();
        chk("R7 A only mode", pd_a, 2); chk("R7 B unselected", pd_b, 0);
        chk("R8 code kept", code_a, 10'h123);
        pulse_start(); send(8'hF0); send(8'h0B); send(8'hF0); send(8'h05); pulse_stop(); settle();
        chk("R7 B mode", pd_b, 3); chk("R8 A floating", pd_a, 1);
        pulse_start(); send(8'hF0); send(8'h04); pulse_stop(); settle();
        chk("R8 wake A", pd_a, 0); chk("R8 resume code", code_a, 10'h123);

        cur_req = "R9";
        pulse_start(); send(8'hF2); pulse_stop(); settle();
        chk("R9 B hi", rd_hi, 8'h34); chk("R9 B lo", rd_lo, 8'h8C);
        pulse_start(); send(8'hF1); pulse_stop(); settle();
        chk("R9 A hi", rd_hi, 8'h04); chk("R9 A lo", rd_lo, 8'h8C);

        cur_req = "R11";
        wr2(4'h4, 10'h3FF); settle();
        pulse_start(); send(8'h30); send(8'hE0); pulse_stop(); settle();
        chk("R11 undefined skip", code_a, 10'h123);
        pulse_start(); send(8'hF5); send(8'hE0); send(8'hC0); send(8'h00); pulse_stop(); settle();
        chk("R11 ext skip", code_a, 10'h123);
        pulse_start(); send(8'hF1); send(8'hE0); pulse_stop(); settle();
        chk("R11 after rd select", code_a, 10'h123);
        pulse_start(); send(8'hE0); pulse_stop(); settle();
        chk("R11 pending survived", code_a, 10'h3FF);

        cur_req = "R4";
        wr2(4'h8, 10'h050); settle();
        chk("R4 A keeps pending", code_a, 10'h3FF); chk("R4 B transferred", code_b, 10'h123);
        pulse_start(); send(8'hE0); pulse_stop(); settle();
        chk("R4 new pending A", code_a, 10'h050);

        cur_req = "R12";
        repeat (5) @(negedge clk);
        chk("R12 idle", code_a, 10'h050);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule